// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block sequences the address and count registers of a single DMA channel. Software programs a source address, a destination address, a transfer count, a block count and a control word while the channel is off. Setting the enable bit arms the channel. Each request then runs bus cycles on a simple internal bus that has no wait states. A dual-address transfer takes a read cycle at the source followed by a write cycle at the destination. A single-address transfer takes one cycle at the source.

Every register changes at a fixed phase of the transfer, so a read during operation always returns a value that has already been updated. Three modes are supported:

- **Normal** runs until the transfer count is used up, then finishes.
- **Repeat** reloads its count and one chosen address after each pass and keeps going until it is stopped.
- **Block** moves one block of transfers back to back for each request, counts the blocks, and reloads the block size and the chosen address between blocks.

In repeat and block modes the reload happens in a single dead cycle that follows the last transfer. A stop input ends operation cleanly at the next idle point.

Top module: `dma_seq`

## Requirements
- R1: Configuration writes are taken only while the enable bit is clear. Selects are 0 source address, 1 destination address, 2 transfer count, 3 block count, 4 control. Control bits are: bit 0 enable, bit 1 single-address, bits 3:2 mode (0 normal, 1 repeat, 2 block), bit 4 word size, bits 6:5 source step, bits 8:7 destination step, bit 9 restore-destination. Reading select 4 returns the control word with the done flag in bit 10. Reads return the live register values at any time.
- R2: A dual-address transfer drives the source address with `bus_rd_o` high in one cycle. In the next cycle it drives the destination address with `bus_wr_o` high. The transfer starts in the clock after `req_i` is sampled high while the channel is enabled and idle.
- R3: The source address steps after its read cycle and the destination address steps after its write cycle. The step code is 0 hold, 1 increment, 2 decrement. The step size is 1 for byte transfers and 2 for word transfers. Addresses wrap modulo 2^AW.
- R4: A single-address transfer is one `bus_rd_o` cycle at the source address. It never changes the destination address.
- R5: The transfer count decrements by one in the read cycle of every transfer, and reads show the new value from the next cycle on.
- R6: In normal mode, the transfer that takes the count from 1 to 0 is the last. After it, `done_o` rises, the enable bit clears and no dead cycle follows.
- R7: In repeat mode, the transfer that empties the count is followed by exactly one `dead_o` cycle. In that cycle the count and the restore-selected address return to their programmed values. The channel stays enabled and done stays low.
- R8: In block mode, one request runs as many back-to-back transfers as the count holds. The block count decrements in the read cycle of the final transfer of the block. A dead cycle then reloads the block size and the restore-selected address. The block count never changes outside block mode.
- R9: In block mode, the dead cycle after the block count reaches zero raises `done_o` and clears the enable bit.
- R10: `stop_i` lets a read/write pair already in progress complete. The channel then goes idle, clears its enable bit and starts no further transfer, even in the middle of a block.
- R11: After reset all registers read zero, the channel is disabled, and `bus_rd_o`, `bus_wr_o`, `dead_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Register select for writes |
| cfg_wdata_i | input | AW | Write data |
| rd_sel_i | input | 3 | Register select for read-back |
| rd_data_o | output | AW | Live read-back value |
| req_i | input | 1 | Transfer request |
| stop_i | input | 1 | Force stop |
| bus_addr_o | output | AW | Bus address |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| dead_o | output | 1 | Dead (reload) cycle indicator |
| done_o | output | 1 | Sticky completion flag, cleared by a control write |

## Verification
The bench sweeps every combination of byte or word size with the hold, increment and decrement step codes for both addresses. The start values sit next to the wrap points, so a wrong step size, a wrong direction or a missing wrap shows up as a wrong bus address.

Repeat and block runs span several passes with the source or the destination chosen for restore. A design that reloaded the wrong address, skipped or doubled the dead cycle, or decremented the block count on every transfer would drift from the computed address and count sequence.

Stop is applied in the middle of a pair and in the middle of a block. A design that aborted the write or carried on through the block would show a missing strobe or an extra read. Writes attempted while the channel is enabled must leave the read-back unchanged.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_DEAD} st_e;
  typedef enum logic [1:0] {MD_NORMAL = 2'd0, MD_REPEAT = 2'd1, MD_BLOCK = 2'd2, MD_RSVD = 2'd3} md_e;
  typedef enum logic [1:0] {SP_HOLD = 2'd0, SP_INC = 2'd1, SP_DEC = 2'd2, SP_RSVD = 2'd3} sp_e;

  typedef struct packed {
    logic area_dst;
    sp_e  dst_sp;
    sp_e  src_sp;
    logic word;
    md_e  mode;
    logic single;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_BLK  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;
endpackage

// File: rtl/dma_addr_reg.sv
`timescale 1ns/1ps
module dma_addr_reg
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          step_i,
  input  sp_e           sp_i,
  input  logic          word_i,
  input  logic          restore_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, init_q, delta;

  assign delta = word_i ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      init_q <= '0;
    end else if (ld_i) begin
      addr_q <= ld_val_i;
      init_q <= ld_val_i;
    end else if (restore_i) begin
      addr_q <= init_q;
    end else if (step_i) begin
      unique case (sp_i)
        SP_INC:  addr_q <= addr_q + delta;
        SP_DEC:  addr_q <= addr_q - delta;
        default: addr_q <= addr_q;
      endcase
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_cnt_reg.sv
`timescale 1ns/1ps
module dma_cnt_reg #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          dec_i,
  input  logic          reload_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      init_q <= '0;
    end else if (ld_i) begin
      cnt_q  <= ld_val_i;
      init_q <= ld_val_i;
    end else if (reload_i) begin
      cnt_q <= init_q;
    end else if (dec_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_seq_fsm.sv
`timescale 1ns/1ps
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_i,
  input  logic stop_i,
  input  logic single_i,
  input  md_e  mode_i,
  input  logic last_i,
  input  logic blk_zero_i,
  output st_e  st_o,
  output logic rd_o,
  output logic wr_o,
  output logic dead_o,
  output logic src_step_o,
  output logic dst_step_o,
  output logic cnt_dec_o,
  output logic blk_dec_o,
  output logic reload_o,
  output logic fin_o
);
  st_e  st_q, st_d, st_post;
  logic last_q, end_now, at_post, rld_mode;

  assign rld_mode = (mode_i == MD_REPEAT) || (mode_i == MD_BLOCK);
  assign end_now  = single_i ? last_i : last_q;
  assign at_post  = (st_q == ST_RD && single_i) || (st_q == ST_WR);

  // decision after a complete read/write pair
  always_comb begin
    if (end_now)                                st_post = rld_mode ? ST_DEAD : ST_IDLE;
    else if (mode_i == MD_BLOCK && !stop_i)     st_post = ST_RD;
    else                                        st_post = ST_IDLE;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (en_i && req_i && !stop_i) st_d = ST_RD;
      ST_RD:   st_d = single_i ? st_post : ST_WR;
      ST_WR:   st_d = st_post;
      ST_DEAD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      last_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RD) last_q <= last_i;
    end
  end

  assign st_o       = st_q;
  assign rd_o       = (st_q == ST_RD);
  assign wr_o       = (st_q == ST_WR);
  assign dead_o     = (st_q == ST_DEAD);
  assign src_step_o = rd_o;
  assign dst_step_o = wr_o;
  assign cnt_dec_o  = rd_o;
  assign blk_dec_o  = rd_o && (mode_i == MD_BLOCK) && last_i;
  assign reload_o   = dead_o;
  assign fin_o      = (at_post && end_now && !rld_mode) ||
                      (dead_o && mode_i == MD_BLOCK && blk_zero_i);

  p_wr_after_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && !single_i |=> wr_o);
  p_dead_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> !dead_o && !rd_o && !wr_o);
  p_no_start_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && !en_i |=> !rd_o);
endmodule

// File: rtl/dma_seq.sv
`timescale 1ns/1ps
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic [2:0]    rd_sel_i,
  output logic [AW-1:0] rd_data_o,
  input  logic          req_i,
  input  logic          stop_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic          dead_o,
  output logic          done_o
);
  localparam int NADDR = 2;

  ctrl_t         ctrl_q;
  logic          done_q, stop_pend_q, stop_any, cfg_acc, idle_stop;
  st_e           st;
  logic          src_step, dst_step, cnt_dec, blk_dec, reload, fin;
  logic [AW-1:0] addr_q [NADDR];
  logic [CW-1:0] xfer_cnt, blk_cnt;

  assign cfg_acc   = cfg_we_i && !ctrl_q.en;
  assign stop_any  = stop_i || stop_pend_q;
  assign idle_stop = (st == ST_IDLE) && ctrl_q.en && stop_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      done_q      <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      if (cfg_acc && cfg_sel_i == SEL_CTRL) ctrl_q <= ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
      else if (fin || idle_stop)            ctrl_q.en <= 1'b0;

      if (cfg_acc && cfg_sel_i == SEL_CTRL) done_q <= 1'b0;
      else if (fin)                         done_q <= 1'b1;

      if (idle_stop || !ctrl_q.en) stop_pend_q <= 1'b0;
      else if (stop_i)             stop_pend_q <= 1'b1;
    end
  end

  dma_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q.en),
    .req_i      (req_i),
    .stop_i     (stop_any),
    .single_i   (ctrl_q.single),
    .mode_i     (ctrl_q.mode),
    .last_i     (xfer_cnt == CW'(1)),
    .blk_zero_i (blk_cnt == '0),
    .st_o       (st),
    .rd_o       (bus_rd_o),
    .wr_o       (bus_wr_o),
    .dead_o     (dead_o),
    .src_step_o (src_step),
    .dst_step_o (dst_step),
    .cnt_dec_o  (cnt_dec),
    .blk_dec_o  (blk_dec),
    .reload_o   (reload),
    .fin_o      (fin)
  );

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    localparam logic       IS_DST = (g == 1);
    localparam logic [2:0] SEL    = IS_DST ? SEL_DST : SEL_SRC;
    dma_addr_reg #(.AW(AW)) u_addr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (cfg_acc && cfg_sel_i == SEL),
      .ld_val_i  (cfg_wdata_i),
      .step_i    (IS_DST ? dst_step : src_step),
      .sp_i      (IS_DST ? ctrl_q.dst_sp : ctrl_q.src_sp),
      .word_i    (ctrl_q.word),
      .restore_i (reload && (ctrl_q.area_dst == IS_DST)),
      .addr_o    (addr_q[g])
    );
  end

  dma_cnt_reg #(.CW(CW)) u_xfer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cfg_acc && cfg_sel_i == SEL_CNT),
    .ld_val_i (cfg_wdata_i[CW-1:0]),
    .dec_i    (cnt_dec),
    .reload_i (reload),
    .cnt_o    (xfer_cnt)
  );

  dma_cnt_reg #(.CW(CW)) u_blk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cfg_acc && cfg_sel_i == SEL_BLK),
    .ld_val_i (cfg_wdata_i[CW-1:0]),
    .dec_i    (blk_dec),
    .reload_i (1'b0),
    .cnt_o    (blk_cnt)
  );

  assign bus_addr_o = bus_wr_o ? addr_q[1] : addr_q[0];
  assign done_o     = done_q;

  always_comb begin
    unique case (rd_sel_i)
      SEL_SRC:  rd_data_o = addr_q[0];
      SEL_DST:  rd_data_o = addr_q[1];
      SEL_CNT:  rd_data_o = AW'(xfer_cnt);
      SEL_BLK:  rd_data_o = AW'(blk_cnt);
      SEL_CTRL: rd_data_o = AW'({done_q, ctrl_q});
      default:  rd_data_o = '0;
    endcase
  end

  p_cfg_lock_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.en |=> $stable(ctrl_q.mode) && $stable(ctrl_q.single) && $stable(ctrl_q.word));
  p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> !bus_rd_o && !bus_wr_o && !dead_o);
  p_done_disables_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !ctrl_q.en);
  p_single_dst_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o && ctrl_q.single |=> $stable(addr_q[1]));
  p_blk_only_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o && ctrl_q.mode != MD_BLOCK |=> $stable(blk_cnt));
endmodule

// File: tb/test_dma_seq.sv
`timescale 1ns/1ps
module test_dma_seq;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wd = '0;
  logic [2:0]    rd_sel = '0;
  logic [AW-1:0] rd_data;
  logic          req = 1'b0, stop = 1'b0;
  logic [AW-1:0] bus_addr;
  logic          bus_rd, bus_wr, dead, done;

  int errs = 0, chks = 0;

  // bench model
  logic [15:0] e_src, e_dst, e_cnt, e_blk, i_src, i_dst, i_cnt;
  logic        e_en, e_done, m_single, m_word, m_area;
  logic [1:0]  m_md, m_ss, m_ds;

  dma_seq #(.AW(AW), .CW(CW)) i_dma_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wd), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .req_i(req), .stop_i(stop), .bus_addr_o(bus_addr), .bus_rd_o(bus_rd),
    .bus_wr_o(bus_wr), .dead_o(dead), .done_o(done)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; chks++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] v);
    rd_sel = s; #0.5; v = rd_data;
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wd = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] stepv(input logic [1:0] sp);
    logic [15:0] d = m_word ? 16'd2 : 16'd1;
    case (sp)
      2'd1: return d;
      2'd2: return -d;
      default: return 16'd0;
    endcase
  endfunction

  task automatic check_regs(string tag);
    logic [15:0] v;
    rd(3'd0, v); chk({tag, " R3 src"}, v, e_src);
    rd(3'd1, v); chk({tag, " R3 dst"}, v, e_dst);
    rd(3'd2, v); chk({tag, " R5 cnt"}, v, e_cnt);
    rd(3'd3, v); chk({tag, " R8 blk"}, v, e_blk);
    rd(3'd4, v); chk({tag, " R6 en/done"}, {v[10], v[0]}, {e_done, e_en});
    chk({tag, " R9 done_o"}, done, e_done);
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                       input logic [15:0] b, input logic [1:0] md, input logic sg,
                       input logic w, input logic [1:0] ss, input logic [1:0] ds, input logic ar);
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, c); wr(3'd3, b);
    wr(3'd4, {6'd0, ar, ds, ss, w, md, sg, 1'b1});
    e_src = s; e_dst = d; e_cnt = c; e_blk = b; i_src = s; i_dst = d; i_cnt = c;
    m_md = md; m_single = sg; m_word = w; m_ss = ss; m_ds = ds; m_area = ar;
    e_en = 1'b1; e_done = 1'b0;
  endtask

  task automatic do_req(string tag);
    int   pairs;
    logic last = 1'b0;
    pairs = (m_md == 2'd2) ? int'(e_cnt) : 1;
    @(negedge clk); req = 1'b1;
    for (int p = 0; p < pairs; p++) begin
      @(negedge clk); req = 1'b0;
      chk({tag, m_single ? " R4 rd" : " R2 rd"}, {bus_rd, bus_wr}, 2'b10);
      chk({tag, " R3 src addr"}, bus_addr, e_src);
      last  = (e_cnt == 16'd1);
      e_src = e_src + stepv(m_ss);
      e_cnt = e_cnt - 16'd1;
      if (m_md == 2'd2 && last) e_blk = e_blk - 16'd1;
      if (!m_single) begin
        @(negedge clk);
        chk({tag, " R2 wr"}, {bus_rd, bus_wr}, 2'b01);
        chk({tag, " R3 dst addr"}, bus_addr, e_dst);
        e_dst = e_dst + stepv(m_ds);
      end
    end
    @(negedge clk);
    if (last && m_md != 2'd0) begin
      chk({tag, " R7 dead"}, dead, 1'b1);
      e_cnt = i_cnt;
      if (m_area) e_dst = i_dst; else e_src = i_src;
      if (m_md == 2'd2 && e_blk == 16'd0) begin e_en = 1'b0; e_done = 1'b1; end
      @(negedge clk);
    end else if (last) begin
      e_en = 1'b0; e_done = 1'b1;
    end
    chk({tag, " R7 idle"}, {dead, bus_rd, bus_wr}, 3'b000);
    check_regs(tag);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v); chk("R11 reset reg", v, 16'd0);
    end
    chk("R11 reset outs", {bus_rd, bus_wr, dead, done}, 4'b0000);
    rst_n = 1'b1;

    // dual normal sweep, addresses near wrap points
    for (int w = 0; w < 2; w++)
      for (int ss = 0; ss < 3; ss++)
        for (int ds = 0; ds < 3; ds++) begin
          setup(16'h0001, 16'hFFFE, 16'd2, 16'd0, 2'd0, 1'b0, w[0], ss[1:0], ds[1:0], 1'b0);
          do_req("normal dual"); do_req("normal dual R6");
        end

    // single normal
    for (int w = 0; w < 2; w++)
      for (int ss = 0; ss < 3; ss++) begin
        setup(16'hFFFF, 16'h1234, 16'd3, 16'd0, 2'd0, 1'b1, w[0], ss[1:0], 2'd1, 1'b0);
        for (int k = 0; k < 3; k++) do_req("normal single R4");
      end

    // repeat mode, both restore choices
    for (int sg = 0; sg < 2; sg++)
      for (int ar = 0; ar < 2; ar++) begin
        setup(16'h0100, 16'h0200, 16'd2, 16'd7, 2'd1, sg[0], 1'b1, 2'd1, 2'd2, ar[0]);
        for (int k = 0; k < 5; k++) do_req("repeat R7");
        // R10 stop ends repeat at idle
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        @(negedge clk); e_en = 1'b0;
        check_regs("repeat stop R10");
      end

    // block mode
    for (int sg = 0; sg < 2; sg++)
      for (int ar = 0; ar < 2; ar++) begin
        setup(16'h3000, 16'h4000, 16'd3, 16'd2, 2'd2, sg[0], ar[0], 2'd1, 2'd1, ar[0]);
        do_req("block R8"); do_req("block R9");
      end

    // R1 writes ignored while enabled
    setup(16'h0010, 16'h0020, 16'd4, 16'd0, 2'd1, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0);
    wr(3'd0, 16'h5555); wr(3'd2, 16'h0009); wr(3'd4, 16'h0005);
    check_regs("R1 locked");
    do_req("R1 live");
    rd(3'd2, v); chk("R1 live cnt", v, 16'd3);

    // R10 stop mid pair in repeat: write still completes
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0; stop = 1'b1;
    chk("R10 rd before stop", bus_rd, 1'b1);
    e_src = e_src + stepv(m_ss); e_cnt = e_cnt - 16'd1;
    @(negedge clk); stop = 1'b0;
    chk("R10 pair completes", bus_wr, 1'b1);
    e_dst = e_dst + stepv(m_ds);
    @(negedge clk);
    @(negedge clk); e_en = 1'b0;
    check_regs("R10 stopped");
    req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R10 no restart", {bus_rd, bus_wr}, 2'b00);
    end
    req = 1'b0;

    // R10 stop mid block
    setup(16'h0500, 16'h0600, 16'd3, 16'd2, 2'd2, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0; stop = 1'b1;
    chk("R10 block rd", {bus_rd, bus_addr}, {1'b1, e_src});
    e_src = e_src + 16'd1; e_cnt = e_cnt - 16'd1;
    @(negedge clk); stop = 1'b0;
    chk("R10 block wr", {bus_wr, bus_addr}, {1'b1, e_dst});
    e_dst = e_dst + 16'd1;
    @(negedge clk);
    chk("R10 block halted", {bus_rd, bus_wr, dead}, 3'b000);
    @(negedge clk); e_en = 1'b0;
    check_regs("R10 block stopped");

    summary();
  end
endmodule